// File: doc/BRIEF.md
# Processor Wait-State Wake Controller

This block decides when a processor core sleeps after a wait instruction retires and when it wakes up again. While the core sleeps, the block drops the core's run enable, so most of the core's logic stops. A free-running cycle counter keeps incrementing on every clock, whether the core is running or asleep.

The block leaves the sleep state when a qualifying interrupt appears. By default, a wake needs a pending line whose mask bit is set and the global interrupt enable must also be set. Such a wake always takes an exception. An optional mode can be switched on by a configuration input. In that mode, a pending line whose mask bit is set ends the sleep even when the global enable is clear. The core then resumes at the next instruction and takes no exception. This allows an idle loop that first disables interrupts, then tests for work, then waits, and that cannot lose a wake event.

A read-only status word reports two things: whether the optional mode is present, and whether the core is currently halted. Pipeline flushing, exception vectoring and saving of the return address are handled elsewhere.

Top module: `wait_wake_ctrl`

## Requirements
- R1: When `wait_retire` is high at a clock edge while the core runs, `run_en` is low after that edge, except in the case covered by R9.
- R2: `cycle_count` is 0 after reset and then grows by exactly 1 on every clock edge, whether the core is asleep or running.
- R3: With `ign_ie_opt` low, a sleeping core wakes only when some line has both `irq_pend` and `irq_mask` set and `glb_ie` is high.
- R4: With `ign_ie_opt` high, a sleeping core wakes when some line has both `irq_pend` and `irq_mask` set, even while `glb_ie` is low.
- R5: A pending line whose mask bit is 0 never ends the sleep, in either mode and for either value of `glb_ie`.
- R6: While the core runs and no wait retires, the interrupt inputs, `glb_ie` and `ign_ie_opt` have no effect: `run_en` stays high and `wake_pulse` stays low.
- R7: `wake_pulse` rises one edge after a qualifying condition is seen while asleep. It lasts exactly one cycle, with `run_en` still low, and `run_en` is high in the next cycle.
- R8: `wake_exc` is high only during `wake_pulse`. It is high exactly when `glb_ie` was high at the edge that decided the wake.
- R9: If a masked-in pending line and a high `glb_ie` are present in the same cycle that a wait retires, the next cycle shows `wake_pulse` and `wake_exc` high without any sleep cycle.
- R10: `status` bit 31 equals `ign_ie_opt`. Bit 0 is 1 whenever `run_en` is low. All other bits are 0.
- R11: A synchronous reset (`rst` high at an edge) returns the block to the running state, with `wake_pulse` and `wake_exc` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wait_retire | input | 1 | Strobe: a wait instruction retires this cycle |
| irq_pend | input | NUM_IRQ | Raw interrupt lines, one per bit |
| irq_mask | input | NUM_IRQ | Per-line enable; 1 lets the line take part |
| glb_ie | input | 1 | Global interrupt enable |
| ign_ie_opt | input | 1 | 1 when the ignore-global-enable-while-asleep option is built in |
| run_en | output | 1 | Core clock enable; 0 while sleeping or waking |
| wake_pulse | output | 1 | One-cycle wake strobe |
| wake_exc | output | 1 | With the strobe: the wake will take an exception |
| cycle_count | output | CNT_W | Free-running cycle counter |
| status | output | 32 | Read-only status word (bit 31 option, bit 0 halted) |

## Verification
A stuck or wrong state in the controller shows up at the ports within one cycle. A sleep state that was never left keeps `run_en` low after a qualifying line appears. A missed transition leaves `wake_pulse` absent at the edge after the condition, or present for two cycles. A stale exception bit shows as a wrong `wake_exc` value during the strobe. A counter that stops while the core sleeps differs from the expected count at the first sleeping cycle. The stimulus walks through both modes, masked lines, a wait that retires with an interrupt already pending, and a reset in the middle of a sleep.

// File: rtl/ww_pkg.sv
package ww_pkg;
   typedef enum logic [1:0] {
      WS_RUN   = 2'd0,
      WS_SLEEP = 2'd1,
      WS_WAKE  = 2'd2
   } ws_state_e;

   localparam int unsigned STAT_W      = 32;
   localparam int unsigned STAT_OPT_BIT = 31;
   localparam int unsigned STAT_HLT_BIT = 0;
endpackage

// File: rtl/ww_irq_qual.sv
module ww_irq_qual #(
   parameter int unsigned NUM_IRQ = 8
) (
   input  logic [NUM_IRQ-1:0] irq_pend,
   input  logic [NUM_IRQ-1:0] irq_mask,
   input  logic               glb_ie,
   input  logic               ign_ie_opt,
   output logic               any_live,
   output logic               take_req,
   output logic               sleep_wake
);
   logic [NUM_IRQ-1:0] live;

   for (genvar i = 0; i < NUM_IRQ; i++) begin : g_line
      assign live[i] = irq_pend[i] & irq_mask[i];
   end

   assign any_live   = |live;
   assign take_req   = any_live & glb_ie;
   assign sleep_wake = any_live & (glb_ie | ign_ie_opt);
endmodule

// File: rtl/ww_cycle_cnt.sv
module ww_cycle_cnt #(
   parameter int unsigned CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst,
   output logic [CNT_W-1:0] count
);
   localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

   always_ff @(posedge clk) begin
      if (rst) count <= '0;
      else     count <= count + ONE;
   end

   AST_COUNT_STEP: assert property (@(posedge clk) disable iff (rst)
      1'b1 |=> (count == $past(count) + ONE)); // R2
endmodule

// File: rtl/ww_fsm.sv
module ww_fsm
   import ww_pkg::*;
(
   input  logic clk,
   input  logic rst,
   input  logic wait_retire,
   input  logic take_req,
   input  logic sleep_wake,
   input  logic glb_ie,
   output ws_state_e state,
   output logic run_en,
   output logic wake_pulse,
   output logic wake_exc
);
   ws_state_e state_d;
   logic      exc_q, exc_d;

   always_comb begin
      state_d = state;
      exc_d   = 1'b0;
      unique case (state)
         WS_RUN: begin
            if (wait_retire) begin
               if (take_req) begin
                  state_d = WS_WAKE;
                  exc_d   = 1'b1;
               end else begin
                  state_d = WS_SLEEP;
               end
            end
         end
         WS_SLEEP: begin
            if (sleep_wake) begin
               state_d = WS_WAKE;
               exc_d   = glb_ie;
            end
         end
         WS_WAKE:  state_d = WS_RUN;
         default:  state_d = WS_RUN;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         state <= WS_RUN;
         exc_q <= 1'b0;
      end else begin
         state <= state_d;
         exc_q <= exc_d;
      end
   end

   assign run_en     = (state == WS_RUN);
   assign wake_pulse = (state == WS_WAKE);
   assign wake_exc   = exc_q;

   AST_RETIRE_HALTS: assert property (@(posedge clk) disable iff (rst)
      (run_en && wait_retire) |=> !run_en); // R1
   AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (rst)
      wake_pulse |=> !wake_pulse); // R7
   AST_RUN_RESUMES: assert property (@(posedge clk) disable iff (rst)
      wake_pulse |=> run_en); // R7
   AST_EXC_IN_PULSE: assert property (@(posedge clk) disable iff (rst)
      wake_exc |-> wake_pulse); // R8
   AST_QUIET_WAKE: assert property (@(posedge clk) disable iff (rst)
      (state == WS_SLEEP && sleep_wake && !glb_ie) |=> (wake_pulse && !wake_exc)); // R4
   AST_EARLY_WAKE: assert property (@(posedge clk) disable iff (rst)
      (run_en && wait_retire && take_req) |=> (wake_pulse && wake_exc)); // R9
endmodule

// File: rtl/wait_wake_ctrl.sv
module wait_wake_ctrl
   import ww_pkg::*;
#(
   parameter int unsigned NUM_IRQ = 8,
   parameter int unsigned CNT_W   = 32
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               wait_retire,
   input  logic [NUM_IRQ-1:0] irq_pend,
   input  logic [NUM_IRQ-1:0] irq_mask,
   input  logic               glb_ie,
   input  logic               ign_ie_opt,
   output logic               run_en,
   output logic               wake_pulse,
   output logic               wake_exc,
   output logic [CNT_W-1:0]   cycle_count,
   output logic [31:0]        status
);
   if (NUM_IRQ < 1 || NUM_IRQ > 32) begin : g_bad_irq
      $error("wait_wake_ctrl: NUM_IRQ must lie in 1..32");
   end
   if (CNT_W < 2 || CNT_W > 64) begin : g_bad_cnt
      $error("wait_wake_ctrl: CNT_W must lie in 2..64");
   end

   logic      any_live, take_req, sleep_wake;
   ws_state_e state;

   ww_irq_qual #(.NUM_IRQ(NUM_IRQ)) u_qual (
      .irq_pend   (irq_pend),
      .irq_mask   (irq_mask),
      .glb_ie     (glb_ie),
      .ign_ie_opt (ign_ie_opt),
      .any_live   (any_live),
      .take_req   (take_req),
      .sleep_wake (sleep_wake)
   );

   ww_fsm u_fsm (
      .clk         (clk),
      .rst         (rst),
      .wait_retire (wait_retire),
      .take_req    (take_req),
      .sleep_wake  (sleep_wake),
      .glb_ie      (glb_ie),
      .state       (state),
      .run_en      (run_en),
      .wake_pulse  (wake_pulse),
      .wake_exc    (wake_exc)
   );

   ww_cycle_cnt #(.CNT_W(CNT_W)) u_cnt (
      .clk   (clk),
      .rst   (rst),
      .count (cycle_count)
   );

   always_comb begin
      status               = '0;
      status[STAT_OPT_BIT] = ign_ie_opt;
      status[STAT_HLT_BIT] = !run_en;
   end

   AST_MASKED_STAYS: assert property (@(posedge clk) disable iff (rst)
      (state == WS_SLEEP && !any_live) |=> !wake_pulse); // R5
   AST_DEFAULT_NEEDS_IE: assert property (@(posedge clk) disable iff (rst)
      (state == WS_SLEEP && !ign_ie_opt && !glb_ie) |=> !wake_pulse); // R3
   AST_RUN_UNDISTURBED: assert property (@(posedge clk) disable iff (rst)
      (run_en && !wait_retire) |=> (run_en && !wake_pulse)); // R6
endmodule

// File: tb/sim_wait_wake_ctrl.sv
module sim_wait_wake_ctrl;
   localparam int NI = 8;
   localparam int CW = 32;

   typedef struct {
      logic  run;
      logic  wake;
      logic  exc;
      logic  opt;
      string tag;
   } exp_t;

   logic          clk = 1'b0;
   logic          rst, wait_retire, glb_ie, ign_ie_opt;
   logic [NI-1:0] irq_pend, irq_mask;
   logic          run_en, wake_pulse, wake_exc;
   logic [CW-1:0] cycle_count;
   logic [31:0]   status;

   int   n_vec = 0;
   int   n_bad = 0;
   logic [CW-1:0] cnt_model;
   exp_t q[$];

   always #2 clk = ~clk;

   wait_wake_ctrl #(.NUM_IRQ(NI), .CNT_W(CW)) u0 (
      .clk(clk), .rst(rst), .wait_retire(wait_retire),
      .irq_pend(irq_pend), .irq_mask(irq_mask), .glb_ie(glb_ie),
      .ign_ie_opt(ign_ie_opt), .run_en(run_en), .wake_pulse(wake_pulse),
      .wake_exc(wake_exc), .cycle_count(cycle_count), .status(status)
   );

   always @(posedge clk) begin
      if (rst) cnt_model <= '0;
      else     cnt_model <= cnt_model + 1'b1;
   end

   // monitor: compares outputs a little after every edge
   always @(posedge clk) begin
      #1;
      if (q.size() > 0) begin
         exp_t e;
         logic [31:0] st;
         e  = q.pop_front();
         st = '0;
         st[31] = e.opt;
         st[0]  = !e.run;
         n_vec++;
         if (run_en !== e.run || wake_pulse !== e.wake || wake_exc !== e.exc) begin
            n_bad++;
            $display("FAIL %s: run/wake/exc got %b%b%b exp %b%b%b", e.tag,
                     run_en, wake_pulse, wake_exc, e.run, e.wake, e.exc);
         end
         if (status !== st) begin
            n_bad++;
            $display("FAIL R10 (%s): status got %h exp %h", e.tag, status, st);
         end
         if (cycle_count !== cnt_model) begin
            n_bad++;
            $display("FAIL R2 (%s): count got %0d exp %0d", e.tag, cycle_count, cnt_model);
         end
      end
   end

   task automatic apply(input logic r, input logic ret, input logic [NI-1:0] p,
                        input logic [NI-1:0] m, input logic ie, input logic op,
                        input logic er, input logic ew, input logic ee, input string tag);
      exp_t e;
      @(negedge clk);
      rst = r; wait_retire = ret; irq_pend = p; irq_mask = m;
      glb_ie = ie; ign_ie_opt = op;
      e.run = er; e.wake = ew; e.exc = ee; e.opt = op; e.tag = tag;
      q.push_back(e);
   endtask

   initial begin
      rst = 1'b1; wait_retire = 1'b0; irq_pend = '0; irq_mask = '0;
      glb_ie = 1'b0; ign_ie_opt = 1'b0;
      // R11 reset state
      apply(1, 0, 8'h00, 8'h00, 0, 0, 1, 0, 0, "R11 reset");
      apply(1, 0, 8'h00, 8'h00, 0, 0, 1, 0, 0, "R11 reset");
      // R6 running core ignores interrupts
      apply(0, 0, 8'hFF, 8'hFF, 1, 0, 1, 0, 0, "R6 run ie");
      apply(0, 0, 8'hFF, 8'hFF, 0, 1, 1, 0, 0, "R6 run opt");
      // default mode wake with exception
      apply(0, 1, 8'h00, 8'hFF, 1, 0, 0, 0, 0, "R1 retire");
      apply(0, 0, 8'h00, 8'hFF, 1, 0, 0, 0, 0, "R1 asleep");
      apply(0, 0, 8'h00, 8'hFF, 1, 0, 0, 0, 0, "R2 asleep count");
      apply(0, 0, 8'h08, 8'hFF, 1, 0, 0, 1, 1, "R7 R8 wake exc");
      apply(0, 0, 8'h00, 8'hFF, 1, 0, 1, 0, 0, "R7 resume");
      // default mode: global enable clear keeps sleeping
      apply(0, 1, 8'h00, 8'h01, 0, 0, 0, 0, 0, "R1 retire");
      apply(0, 0, 8'h01, 8'h01, 0, 0, 0, 0, 0, "R3 no ie");
      apply(0, 0, 8'h01, 8'h01, 0, 0, 0, 0, 0, "R3 no ie");
      apply(0, 0, 8'h01, 8'h01, 1, 0, 0, 1, 1, "R3 ie wake");
      apply(0, 0, 8'h00, 8'h01, 0, 0, 1, 0, 0, "R7 resume");
      // option mode: wake without exception
      apply(0, 1, 8'h00, 8'h04, 0, 1, 0, 0, 0, "R1 retire opt");
      apply(0, 0, 8'h00, 8'h04, 0, 1, 0, 0, 0, "R4 idle");
      apply(0, 0, 8'h04, 8'h04, 0, 1, 0, 1, 0, "R4 R8 quiet wake");
      apply(0, 0, 8'h04, 8'h04, 0, 1, 1, 0, 0, "R7 resume");
      // masked lines
      apply(0, 1, 8'h00, 8'h00, 0, 1, 0, 0, 0, "R1 retire");
      apply(0, 0, 8'hFF, 8'h00, 0, 1, 0, 0, 0, "R5 masked");
      apply(0, 0, 8'h7F, 8'h80, 1, 1, 0, 0, 0, "R5 masked ie");
      apply(0, 0, 8'hFF, 8'h80, 1, 1, 0, 1, 1, "R8 wake ie");
      apply(0, 0, 8'h00, 8'h80, 1, 1, 1, 0, 0, "R7 resume");
      // pending at retire
      apply(0, 1, 8'h02, 8'h02, 1, 0, 0, 1, 1, "R9 early wake");
      apply(0, 0, 8'h02, 8'h02, 1, 0, 1, 0, 0, "R9 resume");
      // option mode, retire with ie clear: sleeps one cycle then wakes
      apply(0, 1, 8'h02, 8'h02, 0, 1, 0, 0, 0, "R1 no early");
      apply(0, 0, 8'h02, 8'h02, 0, 1, 0, 1, 0, "R4 wake");
      apply(0, 0, 8'h00, 8'h02, 0, 1, 1, 0, 0, "R7 resume");
      // reset during sleep
      apply(0, 1, 8'h00, 8'hFF, 0, 0, 0, 0, 0, "R1 retire");
      apply(1, 0, 8'h00, 8'hFF, 0, 0, 1, 0, 0, "R11 reset asleep");
      apply(0, 0, 8'h00, 8'hFF, 1, 0, 1, 0, 0, "R2 after reset");
      apply(0, 0, 8'h00, 8'hFF, 1, 0, 1, 0, 0, "R6 idle");
      @(negedge clk);
      @(negedge clk);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      repeat (5000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end
endmodule